// File: doc/BRIEF.md
# I2C Slave Command Interface

This block lets an external bus master send command bytes to a chip core and read status bytes back over a two-wire I2C bus. It samples SCL and SDA with a fast system clock, at least 20 times the SCL rate. Each line goes through a two-flop synchronizer and then a filter that needs three equal samples in a row. From the filtered levels the block finds start and stop conditions and clock edges. It then runs the address, acknowledge and byte phases of the protocol. The block only pulls SDA low or lets it go; the pull-up is outside the block.

The seven-bit address has a fixed upper part of binary 10000. The two low bits come from strap inputs, so the block answers at 0x40 to 0x43. On a write, each received byte is passed to the core on a one-cycle strobe, with a flag that marks the first byte delivered in the transaction. A separate pulse marks the stop that ends an addressed write. While the core reports busy, the block drops every byte except the abort and stop command codes. It never stretches the clock. Instead, every read starts with a dummy byte that tells the master whether the rest of the data is valid: 0x00 means ready and 0xFF means busy. The bytes that follow come from the core, which moves to its next byte on each load pulse. A repeated start is not supported and ends the transaction.

Top module: `cmd_i2c_slave`

## Requirements
- R1: After reset, sda_oe, wr_valid, wr_first, wr_end and rd_next are all 0.
- R2: The slave answers the address {10000, addr_sel[1:0]} (0x40 to 0x43). The address byte is sent MSB first, and its bit 0 is R/W (0 = write, 1 = read). On a match the slave pulls SDA low (sda_oe = 1) for the whole high phase of the ninth clock.
- R3: When the address does not match, the slave does not acknowledge. Until the next stop it drives nothing and raises no strobe.
- R4: In a write, each data byte is received MSB first and acknowledged on the ninth clock. When the slave is not busy, the byte is delivered on wr_data with a one-cycle wr_valid pulse, in bus order.
- R5: wr_first is high together with wr_valid only for the first byte delivered in a transaction.
- R6: A stop that ends an addressed write gives a one-cycle pulse on wr_end. A read, a non-matching address, or a transaction ended by a repeated start gives no pulse.
- R7: In a read, the first byte returned is 0x00 if busy was low when the address acknowledge ended, and 0xFF if it was high.
- R8: After each byte that the master acknowledges, the slave loads rd_data and pulses rd_next for one cycle. It then sends the loaded byte MSB first, with sda_oe = 1 for each 0 bit.
- R9: After the master answers a read byte with a NACK, the slave releases SDA until the next stop and pulses rd_next no more.
- R10: While busy is high, written bytes other than the abort code 0x01 and the stop code 0x02 are acknowledged but not delivered. The codes 0x01 and 0x02 are still delivered.
- R11: A start in the middle of a transaction ends it. The slave then acknowledges nothing and delivers nothing until the next stop, after which a new transaction works normally.
- R12: An SCL high pulse shorter than three system-clock samples is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Strap bits for the two low bits of the address |
| busy | input | 1 | Core busy flag |
| rd_data | input | 8 | Next status byte from the core |
| rd_next | output | 1 | One-cycle pulse when rd_data is loaded |
| wr_data | output | 8 | Received command byte |
| wr_valid | output | 1 | One-cycle strobe for wr_data |
| wr_first | output | 1 | Marks the first byte delivered in the transaction |
| wr_end | output | 1 | One-cycle pulse on the stop that ends an addressed write |

## Verification
The bench sends bytes while busy is high and checks two things: that bytes other than the abort and stop codes are still acknowledged but never strobed, and that the first-byte flag moves to the first byte actually delivered. A design that filtered on the wrong cycle would leak a dropped byte or lose an abort. A repeated start is sent in the middle of a write. A slave that treated it as a fresh start would acknowledge the next address and raise an end pulse, and the bench catches this. Reads are run both ready and busy to check the dummy byte. They also test that a master NACK makes the slave release SDA and stop loading bytes, since a slave that kept driving would hold the bus. A one-cycle SCL glitch is placed inside a data bit, so a design without the filter would shift in an extra bit and deliver a wrong byte.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_SKIP
    } slv_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [1:0]       sync;
        logic [DEPTH-1:0] hist;
        logic             level;
        logic             rise;
        logic             fall;
    } flt_t;

    flt_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], line_i};
        r_d.hist = {r_q.hist[DEPTH-2:0], r_q.sync[1]};
        if (&r_q.hist) begin
            r_d.level = 1'b1;
        end else if (~|r_q.hist) begin
            r_d.level = 1'b0;
        end
        r_d.rise = r_d.level & ~r_q.level;
        r_d.fall = ~r_d.level & r_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: '1, hist: '1, level: 1'b1, rise: 1'b0, fall: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.level;
    assign rise_o  = r_q.rise;
    assign fall_o  = r_q.fall;
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SEL_W  = 2,
    parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI = 5'b10000,
    parameter logic [7:0] ABORT_CODE = 8'h01,
    parameter logic [7:0] STOP_CODE  = 8'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [SEL_W-1:0] addr_sel,
    input  logic             busy,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic [7:0]       wr_data,
    output logic             wr_valid,
    output logic             wr_first,
    output logic             wr_end,
    output logic             rd_next
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        slv_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              first;
        logic              nack;
        logic              oe;
        logic [7:0]        wdat;
        logic              wval;
        logic              wfirst;
        logic              wend;
        logic              rnext;
    } eng_t;

    eng_t r_q, r_d;
    logic start_ev, stop_ev;

    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;

    always_comb begin
        r_d        = r_q;
        r_d.wval   = 1'b0;
        r_d.wfirst = 1'b0;
        r_d.wend   = 1'b0;
        r_d.rnext  = 1'b0;
        if (stop_ev) begin
            r_d.wend = (r_q.st == ST_WRITE) || (r_q.st == ST_WRITE_ACK);
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b0;
        end else if (start_ev) begin
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
            r_d.st  = (r_q.st == ST_IDLE) ? ST_ADDR : ST_SKIP;
        end else begin
            case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        if (r_q.sh[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
                            r_d.oe = 1'b1;
                            r_d.rw = r_q.sh[0];
                            r_d.st = ST_ADDR_ACK;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.sh = {BYTE_W{busy}};
                            r_d.oe = ~busy;
                            r_d.st = ST_READ;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.first = 1'b1;
                            r_d.st    = ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.oe = 1'b1;
                        r_d.st = ST_WRITE_ACK;
                        if (!busy || r_q.sh == ABORT_CODE || r_q.sh == STOP_CODE) begin
                            r_d.wval   = 1'b1;
                            r_d.wdat   = r_q.sh;
                            r_d.wfirst = r_q.first;
                            r_d.first  = 1'b0;
                        end
                    end
                end
                ST_WRITE_ACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WRITE;
                    end
                end
                ST_READ: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_READ_ACK;
                        end else begin
                            r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.nack) begin
                            r_d.st = ST_SKIP;
                        end else begin
                            r_d.sh    = rd_data;
                            r_d.oe    = ~rd_data[7];
                            r_d.rnext = 1'b1;
                            r_d.cnt   = '0;
                            r_d.st    = ST_READ;
                        end
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe   = r_q.oe;
    assign wr_data  = r_q.wdat;
    assign wr_valid = r_q.wval;
    assign wr_first = r_q.wfirst;
    assign wr_end   = r_q.wend;
    assign rd_next  = r_q.rnext;
endmodule

// File: rtl/cmd_i2c_slave.sv
module cmd_i2c_slave #(
    parameter int ADDR_W = 7,
    parameter int SEL_W  = 2,
    parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI = 5'b10000,
    parameter logic [7:0] ABORT_CODE = 8'h01,
    parameter logic [7:0] STOP_CODE  = 8'h02,
    parameter int FILT_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] addr_sel,
    input  logic             busy,
    input  logic [7:0]       rd_data,
    output logic             rd_next,
    output logic [7:0]       wr_data,
    output logic             wr_valid,
    output logic             wr_first,
    output logic             wr_end
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_glitch_filter #(.DEPTH(FILT_DEPTH)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    i2c_cmd_engine #(
        .ADDR_W     (ADDR_W),
        .SEL_W      (SEL_W),
        .ADDR_HI    (ADDR_HI),
        .ABORT_CODE (ABORT_CODE),
        .STOP_CODE  (STOP_CODE)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[0]),
        .scl_rise (rise[0]),
        .scl_fall (fall[0]),
        .sda_lvl  (lvl[1]),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .addr_sel (addr_sel),
        .busy     (busy),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .wr_first (wr_first),
        .wr_end   (wr_end),
        .rd_next  (rd_next)
    );
endmodule

// File: rtl/i2c_cmd_checker.sv
module i2c_cmd_checker #(
    parameter logic [7:0] ABORT_CODE = 8'h01,
    parameter logic [7:0] STOP_CODE  = 8'h02
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       busy,
    input logic       sda_oe,
    input logic       rd_next,
    input logic [7:0] wr_data,
    input logic       wr_valid,
    input logic       wr_first,
    input logic       wr_end
);
    // R6: end marker lasts one cycle
    assert_end_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> !wr_end);

    // R8: load pulse lasts one cycle and never coincides with a write strobe
    assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_next |=> !rd_next);
    assert_no_mixed_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_next && wr_valid));

    // R5: first flag only with a strobe
    assert_first_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_first |-> wr_valid);

    // R10: a byte delivered right after busy was high must be abort or stop
    assert_busy_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(busy)) |-> (wr_data == ABORT_CODE || wr_data == STOP_CODE));

    // R2: the slave changes SDA only while SCL is low
    assert_sda_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind cmd_i2c_slave i2c_cmd_checker #(
    .ABORT_CODE (ABORT_CODE),
    .STOP_CODE  (STOP_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .rd_next  (rd_next),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .wr_first (wr_first),
    .wr_end   (wr_end)
);

// File: tb/sim_cmd_i2c_slave.sv
`timescale 1ns/1ps
module sim_cmd_i2c_slave;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] addr_sel = 2'b10;
    logic       busy = 1'b0;
    logic [7:0] rd_data;
    logic       sda_oe, rd_next, wr_valid, wr_first, wr_end;
    logic [7:0] wr_data;
    logic       sda_line;

    int errors = 0, checks = 0;
    int rd_cnt = 0, end_cnt = 0, exp_end = 0;
    bit chk_en = 1'b0, done = 1'b0;
    logic exp_oe = 1'b0;
    string cur_req = "R1";
    logic [8:0] exp_wq[$];

    always #10 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    function automatic logic [7:0] src(int i);
        return 8'hA5 ^ 8'(i * 59);
    endfunction
    assign rd_data = src(rd_cnt);

    cmd_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .busy(busy), .rd_data(rd_data), .rd_next(rd_next),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_first(wr_first), .wr_end(wr_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: expected SDA drive per clock while SCL is high,
    // expected write stream in a queue, pulse counters.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (chk_en && m_scl) check(sda_oe == exp_oe, cur_req, sda_oe, exp_oe);
            if (wr_valid) begin
                if (exp_wq.size() == 0) check(1'b0, "R10 unexpected strobe", {wr_first, wr_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_wq.pop_front();
                    check({wr_first, wr_data} == e, "R4/R5 write byte", {wr_first, wr_data}, e);
                end
            end
            if (wr_end) end_cnt++;
            if (rd_next) rd_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        tick(HALF/2); m_low = 1'b1;
        tick(HALF/2); m_scl = 1'b0;
        tick(HALF/2);
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        m_low = 1'b1;
        tick(HALF/2); m_scl = 1'b1;
        tick(HALF/2); m_low = 1'b0;
        tick(HALF);
    endtask

    task automatic bit_out(input logic b, input logic e, input bit glitch);
        m_low = ~b; exp_oe = e;
        if (glitch) begin
            tick(10); m_scl = 1'b1; tick(1); m_scl = 1'b0; tick(HALF/2 - 11);
        end else tick(HALF/2);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0; tick(HALF/2);
    endtask

    task automatic bit_in(input logic e, output logic got);
        m_low = 1'b0; exp_oe = e;
        tick(HALF/2); m_scl = 1'b1;
        tick(HALF/2); got = sda_line;
        tick(HALF/2); m_scl = 1'b0;
        tick(HALF/2);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input int glitch_at);
        logic g;
        for (int i = 7; i >= 0; i--) bit_out(b[i], 1'b0, i == glitch_at);
        bit_in(ack, g);
        check(g == ~ack, {cur_req, " ack level"}, g, ~ack);
    endtask

    task automatic recv_byte(input logic [7:0] e, input bit mack);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) bit_in(~e[i], got[i]);
        check(got == e, {cur_req, " read byte"}, got, e);
        bit_out(~mack, 1'b0, 1'b0);
    endtask

    initial begin
        int base;
        logic dummy;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check({sda_oe, wr_valid, wr_first, wr_end, rd_next} == 5'b0, "R1", {sda_oe, wr_valid, wr_first, wr_end, rd_next}, 0);
        chk_en = 1'b1;

        // R2 R4 R5 R6: plain write to 0x42
        cur_req = "R2/R4"; addr_sel = 2'b10;
        bus_start();
        send_byte(8'h84, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h5A}); send_byte(8'h5A, 1'b1, -1);
        exp_wq.push_back({1'b0, 8'hC3}); send_byte(8'hC3, 1'b1, -1);
        exp_end++; bus_stop();
        check(end_cnt == exp_end, "R6 end pulse", end_cnt, exp_end);

        // R2: other strap value 0x43
        addr_sel = 2'b11; cur_req = "R2 addr 0x43";
        bus_start();
        send_byte(8'h86, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h3C}); send_byte(8'h3C, 1'b1, -1);
        exp_end++; bus_stop();

        // R3: mismatched address, then data ignored
        addr_sel = 2'b10; cur_req = "R3 mismatch";
        bus_start();
        send_byte(8'h86, 1'b0, -1);
        send_byte(8'h77, 1'b0, -1);
        bus_stop();
        check(end_cnt == exp_end, "R3 no end pulse", end_cnt, exp_end);

        // R7 R8 R9: read ready
        cur_req = "R7/R8"; base = rd_cnt;
        bus_start();
        send_byte(8'h85, 1'b1, -1);
        recv_byte(8'h00, 1'b1);
        recv_byte(src(base), 1'b1);
        recv_byte(src(base + 1), 1'b0);
        cur_req = "R9 released after nack";
        for (int i = 0; i < 9; i++) bit_in(1'b0, dummy);
        bus_stop();
        check(rd_cnt - base == 2, "R8 load count", rd_cnt - base, 2);
        check(end_cnt == exp_end, "R6 no end on read", end_cnt, exp_end);

        // R7: read while busy
        busy = 1'b1; cur_req = "R7 busy dummy"; base = rd_cnt;
        bus_start();
        send_byte(8'h85, 1'b1, -1);
        recv_byte(8'hFF, 1'b0);
        bus_stop();
        check(rd_cnt == base, "R9 no load after nack", rd_cnt, base);

        // R10: busy filtering on writes
        cur_req = "R10 busy write";
        bus_start();
        send_byte(8'h84, 1'b1, -1);
        send_byte(8'h33, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h02}); send_byte(8'h02, 1'b1, -1);
        exp_wq.push_back({1'b0, 8'h01}); send_byte(8'h01, 1'b1, -1);
        send_byte(8'h55, 1'b1, -1);
        exp_end++; bus_stop();
        busy = 1'b0;
        check(exp_wq.size() == 0, "R10 queue drained", exp_wq.size(), 0);

        // R11: repeated start aborts
        cur_req = "R11 repeated start";
        bus_start();
        send_byte(8'h84, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h11}); send_byte(8'h11, 1'b1, -1);
        m_low = 1'b0; exp_oe = 1'b0;
        tick(HALF/2); m_scl = 1'b1;
        tick(HALF/2); m_low = 1'b1;
        tick(HALF/2); m_scl = 1'b0;
        tick(HALF/2);
        send_byte(8'h84, 1'b0, -1);
        send_byte(8'h22, 1'b0, -1);
        bus_stop();
        check(end_cnt == exp_end, "R11 no end pulse", end_cnt, exp_end);
        cur_req = "R11 recovery";
        bus_start();
        send_byte(8'h84, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h77}); send_byte(8'h77, 1'b1, -1);
        exp_end++; bus_stop();

        // R12: SCL glitch inside a data bit
        cur_req = "R12 glitch";
        bus_start();
        send_byte(8'h84, 1'b1, -1);
        exp_wq.push_back({1'b1, 8'h96}); send_byte(8'h96, 1'b1, 4);
        exp_end++; bus_stop();

        tick(10);
        check(exp_wq.size() == 0, "R4 all bytes delivered", exp_wq.size(), 0);
        check(end_cnt == exp_end, "R6 end count", end_cnt, exp_end);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule